// File: doc/BRIEF.md
# Power Button Filter with Forced-Off Timer

This block conditions the active-low power button of a platform power sequencer. A filter rejects contact bounce. A configuration bit chooses how a press is recognised. In filtered mode a press counts only after the pin has stayed low for a full filter window. In immediate mode the first falling edge counts at once, and further falling edges are not acted on until a lockout window has passed. Each recognised press gives a one-cycle event. A readable level shows whether the button is held now.

A second function watches the filtered button level. If the filtered level stays low for a programmable number of clock ticks, the block emits a one-cycle forced-off request, whatever the recognition mode. While the sleep-signal minimum-width stretch is running, press events are kept pending and are released when the stretch ends. If the stretch also follows a graceful sleep entry or a host reset with power cycle, the forced-off period is replaced by a longer fixed period. After power restoration the caller leaves the qualifier low, and the normal period applies.

The filter length and the extended period are parameters in clock ticks. The surrounding sleep-state controller supplies the stretch indications.

Top module: `pb_ctrl`

## Requirements
- R1: After reset, `press_evt` and `override_evt` are 0 and `btn_level` is 0.
- R2: With `cfg_immediate`=0, `press_evt` pulses in the cycle after the pin has been sampled low on DB_TICKS consecutive clock edges. A low pulse shorter than DB_TICKS samples gives no event.
- R3: With `cfg_immediate`=1, `press_evt` pulses in the cycle after the first edge that samples the pin low, following a high sample.
- R4: With `cfg_immediate`=1, falling edges sampled on the DB_TICKS edges after an accepted one give no event. The first falling edge after that window is accepted.
- R5: `btn_level` is 1 while pressed. With `cfg_immediate`=0 it shows the filtered level. With `cfg_immediate`=1 it shows the pin as sampled on the previous edge.
- R6: `override_evt` pulses once the filtered level has been low for `cfg_ovr_ticks` edges, which is DB_TICKS+`cfg_ovr_ticks` edges after the first low sample of a clean press. A shorter press gives no pulse.
- R7: `override_evt` lasts one cycle and does not fire again until the filtered level has returned high.
- R8: While `stretch_active`=1 and `stretch_ext_ok`=1, the forced-off period is EXT_TICKS instead of `cfg_ovr_ticks`. When the stretch drops after the count has passed `cfg_ovr_ticks`, the pulse fires on the next edge.
- R9: With `stretch_ext_ok`=0, `stretch_active` does not lengthen the forced-off period.
- R10: A press recognised while `stretch_active`=1 gives no event during the stretch. Its event comes in the cycle after the first edge that samples `stretch_active` low.
- R11: In immediate mode the forced-off timer still counts from the filtered level, so it fires DB_TICKS+`cfg_ovr_ticks` edges after the first low sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_btn_n | input | 1 | Button pin, low when pressed, synchronous to clk |
| cfg_immediate | input | 1 | 0: act after filtering, 1: act on edge then lock out |
| cfg_ovr_ticks | input | CNT_W | Normal forced-off period in clock ticks |
| stretch_active | input | 1 | Sleep-signal minimum-width stretch running |
| stretch_ext_ok | input | 1 | Stretch follows graceful sleep entry or a power-cycling host reset |
| press_evt | output | 1 | One-cycle press event |
| override_evt | output | 1 | One-cycle forced-off request |
| btn_level | output | 1 | Button currently pressed (source set by mode) |

## Verification
A held press event and the forced-off pulse can come out in the same cycle. This happens when a press is held through a stretch with the extension active, and the stretch then ends after the hold has passed the normal period. The bench holds the button for longer than the normal period but shorter than the extended one, and keeps the stretch up the whole time. It then drops the stretch and expects both outputs high on the following sample, with neither seen before. Randomly sized sub-window bounces, from a fixed seed, show that the filter alone produces neither output.

// File: rtl/pbc_pkg.sv
`timescale 1ns/1ps
package pbc_pkg;
   typedef enum logic {
      MODE_FILTERED  = 1'b0,
      MODE_IMMEDIATE = 1'b1
   } pb_mode_e;
endpackage

// File: rtl/pb_filter.sv
`timescale 1ns/1ps
// Holds a stable copy of the pin; flips it after DB_TICKS consecutive
// disagreeing samples. fall_now flags the edge at which it flips low.
module pb_filter #(
   parameter int DB_TICKS = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_n,
   output logic filt_n,
   output logic fall_now
);
   generate
      if (DB_TICKS == 1) begin : g_pass
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) filt_n <= 1'b1;
            else        filt_n <= raw_n;
         end
         assign fall_now = filt_n & ~raw_n;
      end else begin : g_count
         localparam int CW = (DB_TICKS > 2) ? $clog2(DB_TICKS) : 1;
         localparam logic [CW-1:0] LAST = CW'(DB_TICKS - 1);
         logic [CW-1:0] cnt;
         logic          differ;
         logic          flip;

         always_comb begin
            differ = (raw_n != filt_n);
            flip   = differ && (cnt == LAST);
         end
         assign fall_now = flip & ~raw_n;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               filt_n <= 1'b1;
               cnt    <= '0;
            end else if (!differ) begin
               cnt <= '0;
            end else if (flip) begin
               filt_n <= raw_n;
               cnt    <= '0;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/pb_lockout.sv
`timescale 1ns/1ps
// Edge detector on the raw pin with a DB_TICKS lockout after each hit.
module pb_lockout #(
   parameter int DB_TICKS = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_n,
   output logic raw_q,
   output logic hit
);
   localparam int LW = $clog2(DB_TICKS + 1);
   localparam logic [LW-1:0] LOAD = LW'(DB_TICKS);
   logic [LW-1:0] lock;

   assign hit = ~raw_n & raw_q & (lock == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         raw_q <= 1'b1;
         lock  <= '0;
      end else begin
         raw_q <= raw_n;
         if (hit)             lock <= LOAD;
         else if (lock != '0) lock <= lock - 1'b1;
      end
   end
endmodule

// File: rtl/pb_override.sv
`timescale 1ns/1ps
// Counts edges with the filtered level low; one pulse per continuous hold.
module pb_override #(
   parameter int CNT_W     = 12,
   parameter int EXT_TICKS = 200
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             filt_n,
   input  logic             ext_sel,
   input  logic [CNT_W-1:0] cfg_ticks,
   output logic             fire
);
   localparam logic [CNT_W-1:0] EXT_VAL = CNT_W'(EXT_TICKS);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] limit;
   logic             done;
   logic             reach;

   always_comb begin
      limit = ext_sel ? EXT_VAL : cfg_ticks;
      reach = ({1'b0, cnt} + {{CNT_W{1'b0}}, 1'b1}) >= {1'b0, limit};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         done <= 1'b0;
         fire <= 1'b0;
      end else begin
         fire <= 1'b0;
         if (filt_n) begin
            cnt  <= '0;
            done <= 1'b0;
         end else begin
            if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
            if (!done && reach) begin
               fire <= 1'b1;
               done <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/pb_ctrl.sv
`timescale 1ns/1ps
module pb_ctrl
   import pbc_pkg::*;
#(
   parameter int DB_TICKS  = 800_000,
   parameter int CNT_W     = 30,
   parameter int EXT_TICKS = 475_000_000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pwr_btn_n,
   input  logic             cfg_immediate,
   input  logic [CNT_W-1:0] cfg_ovr_ticks,
   input  logic             stretch_active,
   input  logic             stretch_ext_ok,
   output logic             press_evt,
   output logic             override_evt,
   output logic             btn_level
);
   generate
      if (DB_TICKS < 1) begin : g_bad_db
         $error("pb_ctrl: DB_TICKS must be at least 1");
      end
      if (CNT_W < 2 || CNT_W > 31) begin : g_bad_w
         $error("pb_ctrl: CNT_W out of range");
      end
      if (EXT_TICKS < 1 || longint'(EXT_TICKS) >= (longint'(1) << CNT_W)) begin : g_bad_ext
         $error("pb_ctrl: EXT_TICKS does not fit CNT_W");
      end
   endgenerate

   pb_mode_e mode;
   logic     filt_n;
   logic     flt_fall;
   logic     raw_q;
   logic     lk_hit;
   logic     recog;
   logic     pend;

   assign mode = pb_mode_e'(cfg_immediate);

   pb_filter #(.DB_TICKS(DB_TICKS)) u_filter (
      .clk      (clk),
      .rst_n    (rst_n),
      .raw_n    (pwr_btn_n),
      .filt_n   (filt_n),
      .fall_now (flt_fall)
   );

   pb_lockout #(.DB_TICKS(DB_TICKS)) u_lockout (
      .clk   (clk),
      .rst_n (rst_n),
      .raw_n (pwr_btn_n),
      .raw_q (raw_q),
      .hit   (lk_hit)
   );

   pb_override #(.CNT_W(CNT_W), .EXT_TICKS(EXT_TICKS)) u_override (
      .clk       (clk),
      .rst_n     (rst_n),
      .filt_n    (filt_n),
      .ext_sel   (stretch_active & stretch_ext_ok),
      .cfg_ticks (cfg_ovr_ticks),
      .fire      (override_evt)
   );

   always_comb begin
      recog     = (mode == MODE_IMMEDIATE) ? lk_hit : flt_fall;
      btn_level = (mode == MODE_IMMEDIATE) ? ~raw_q : ~filt_n;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         press_evt <= 1'b0;
         pend      <= 1'b0;
      end else begin
         press_evt <= 1'b0;
         if ((recog || pend) && !stretch_active) begin
            press_evt <= 1'b1;
            pend      <= 1'b0;
         end else if (recog) begin
            pend <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/pb_ctrl_chk.sv
`timescale 1ns/1ps
module pb_ctrl_chk (
   input logic clk,
   input logic rst_n,
   input logic pwr_btn_n,
   input logic cfg_immediate,
   input logic stretch_active,
   input logic filt_n,
   input logic press_evt,
   input logic override_evt,
   input logic btn_level
);
   // R10
   hold_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stretch_active |=> !press_evt);

   // R7
   ovr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      override_evt |=> !override_evt);

   // R11
   ovr_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      override_evt |-> !$past(filt_n));

   // R5
   lvl_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_immediate |-> (btn_level == !$past(pwr_btn_n)));
endmodule

bind pb_ctrl pb_ctrl_chk u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .pwr_btn_n      (pwr_btn_n),
   .cfg_immediate  (cfg_immediate),
   .stretch_active (stretch_active),
   .filt_n         (filt_n),
   .press_evt      (press_evt),
   .override_evt   (override_evt),
   .btn_level      (btn_level)
);

// File: tb/test_pb_ctrl.sv
`timescale 1ns/1ps
module test_pb_ctrl;
   localparam int DB  = 8;
   localparam int CW  = 12;
   localparam int EXT = 200;
   localparam int L   = 40;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          btn_n = 1'b1;
   logic          imm = 1'b0;
   logic [CW-1:0] ovr_ticks = CW'(L);
   logic          str = 1'b0;
   logic          ext_ok = 1'b0;
   logic          press_evt, override_evt, btn_level;

   int checks = 0;
   int errors = 0;
   int n_evt = 0;
   int n_ovr = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   pb_ctrl #(.DB_TICKS(DB), .CNT_W(CW), .EXT_TICKS(EXT)) i_pb_ctrl (
      .clk(clk), .rst_n(rst_n), .pwr_btn_n(btn_n), .cfg_immediate(imm),
      .cfg_ovr_ticks(ovr_ticks), .stretch_active(str), .stretch_ext_ok(ext_ok),
      .press_evt(press_evt), .override_evt(override_evt), .btn_level(btn_level)
   );

   task automatic step(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (press_evt)    n_evt++;
         if (override_evt) n_ovr++;
      end
   endtask

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int rand_len(input int lo, input int span);
      return lo + int'($urandom % span);
   endfunction

   initial begin
      repeat (30000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual 0 expected 1");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      step(3);
      rst_n = 1'b1;
      step(1);
      // R1
      chk("R1 press", int'(press_evt), 0);
      chk("R1 override", int'(override_evt), 0);
      chk("R1 level", int'(btn_level), 0);

      // R2 R5 R6 R7: filtered mode, long hold
      btn_n = 1'b0;
      step(DB - 1);
      chk("R2 early", int'(press_evt), 0);
      step(1);
      chk("R2 on time", int'(press_evt), 1);
      chk("R5 filtered level", int'(btn_level), 1);
      step(L - 1);
      chk("R6 early", int'(override_evt), 0);
      step(1);
      chk("R6 on time", int'(override_evt), 1);
      n_ovr = 0;
      step(3 * L);
      chk("R7 no refire", n_ovr, 0);
      btn_n = 1'b1;
      step(1);
      chk("R5 filtered hold", int'(btn_level), 1);
      step(DB + 2);
      chk("R5 filtered release", int'(btn_level), 0);

      // R6: short press gives no override
      n_ovr = 0;
      btn_n = 1'b0;
      step(L - 5);
      btn_n = 1'b1;
      step(DB + L);
      chk("R6 short press", n_ovr, 0);

      // R2: random sub-window bounces
      n_evt = 0;
      n_ovr = 0;
      for (int i = 0; i < 20; i++) begin
         btn_n = 1'b0;
         step(rand_len(1, DB - 1));
         btn_n = 1'b1;
         step(rand_len(DB, 5));
      end
      chk("R2 bounce events", n_evt, 0);
      chk("R6 bounce override", n_ovr, 0);

      // R3 R4 R5 R11: immediate mode
      imm = 1'b1;
      step(1);
      btn_n = 1'b0;
      step(1);
      chk("R3 immediate", int'(press_evt), 1);
      chk("R5 raw level", int'(btn_level), 1);
      step(1);
      btn_n = 1'b1;
      step(1);
      chk("R5 raw release", int'(btn_level), 0);
      n_evt = 0;
      btn_n = 1'b0; step(1);
      btn_n = 1'b1; step(1);
      btn_n = 1'b0; step(1);
      btn_n = 1'b1; step(1);
      chk("R4 lockout", n_evt, 0);
      step(DB + 4);
      btn_n = 1'b0;
      step(1);
      chk("R4 after lockout", int'(press_evt), 1);
      step(DB + L - 2);
      chk("R11 early", int'(override_evt), 0);
      step(1);
      chk("R11 on time", int'(override_evt), 1);
      btn_n = 1'b1;
      step(DB + 4);
      imm = 1'b0;

      // R8 R10: held event and override in the same cycle
      str = 1'b1;
      ext_ok = 1'b1;
      n_evt = 0;
      n_ovr = 0;
      btn_n = 1'b0;
      step(DB + L + 10);
      chk("R10 held", n_evt, 0);
      chk("R8 extended", n_ovr, 0);
      str = 1'b0;
      step(1);
      chk("R10 coincide press", int'(press_evt), 1);
      chk("R8 coincide override", int'(override_evt), 1);
      btn_n = 1'b1;
      step(DB + 4);

      // R8: full extended period
      str = 1'b1;
      btn_n = 1'b0;
      step(DB + EXT - 1);
      chk("R8 ext early", int'(override_evt), 0);
      step(1);
      chk("R8 ext on time", int'(override_evt), 1);
      btn_n = 1'b1;
      step(DB + 4);
      str = 1'b0;
      step(1);
      chk("R10 delivered", int'(press_evt), 1);

      // R9: stretch without qualifier keeps normal period
      str = 1'b1;
      ext_ok = 1'b0;
      btn_n = 1'b0;
      step(DB + L - 1);
      chk("R9 early", int'(override_evt), 0);
      step(1);
      chk("R9 on time", int'(override_evt), 1);
      btn_n = 1'b1;
      step(DB + 4);
      str = 1'b0;
      step(2);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule